// File: doc/BRIEF.md
# Dual-Threshold Buffer Interrupt Generator

This block follows the byte offset that a streaming data mover has reached inside a circular buffer. It raises one interrupt per programmable threshold when that offset lands on the threshold value. The usual setup puts one threshold at mid-buffer and the other at the final eight bytes. With that setup the host can drain or refill one half of the buffer while the mover works on the other half.

One instance serves one direction. On a receive path the mover reports an advance each time it writes bytes into the buffer. On a transmit path it reports an advance each time it reads bytes out. The block holds the two threshold offsets, a per-threshold enable bit, a per-threshold output-style bit (pulse or level) and two sticky status bits. All of these sit behind a small single-cycle register port.

Top module: `bufthr_irq`

## Requirements
- R1: After reset all four registers read as zero and both interrupt outputs are low.
- R2: Register map on `addr_i`: 0 holds threshold A and 1 holds threshold B, each a full offset. Address 2 is control, with bit 0 enable A, bit 1 enable B, bit 2 style A and bit 3 style B (1 = level, 0 = pulse). Address 3 is status, with bit 0 for A and bit 1 for B. Unused bits read as zero, and written values read back unchanged.
- R3: A cycle with `adv_i` high and `ofs_i` equal to a threshold sets that threshold's status bit on the next cycle. The bit then stays set until the host clears it.
- R4: An interrupt output is high only while its status bit is set. With the enable bit low, a crossing still sets status but leaves the output low.
- R5: In pulse style with the enable set, a crossing drives the output high for exactly the one cycle after the crossing cycle. The status bit is set as well.
- R6: Writing 1 to a status bit clears it on the next cycle. Writing 0 leaves it unchanged.
- R7: A status write of 1 in the same cycle as a crossing on that threshold leaves the bit set.
- R8: Detection happens only in cycles where `adv_i` is high. Holding the offset on a threshold without advancing does not retrigger. Advancing around the ring through offset 0 and back onto the threshold triggers again.
- R9: In level style the output equals status AND enable. Clearing the enable drops the output on the next cycle while the status bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| adv_i | input | 1 | The mover advanced to `ofs_i` this cycle |
| ofs_i | input | OFS_W | Current byte offset in the buffer |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | OFS_W | Register write data |
| rdata_o | output | OFS_W | Register read data for `addr_i` (combinational) |
| irq_o | output | 2 | Interrupt per threshold (bit 0 = A, bit 1 = B) |

## Verification
Status bits, pulse outputs and register writes become visible one clock after the cycle in which the advance or write is presented. A level output follows in that same later cycle because it is formed from registered state. Read data is combinational from the address and the current state.

The bench applies each stimulus at a falling edge. It lets one rising edge register the stimulus and compares every output and the read data at the following falling edge against a bench-side model that advances by exactly one cycle per step. Full 256-offset ring walks are repeated over sixteen threshold pairs and all four style combinations.

// File: rtl/bufthr_pkg.sv
package bufthr_pkg;
    localparam int NTHR = 2;

    localparam logic [1:0] A_THR0 = 2'd0;
    localparam logic [1:0] A_THR1 = 2'd1;
    localparam logic [1:0] A_CTRL = 2'd2;
    localparam logic [1:0] A_STAT = 2'd3;

    typedef struct packed {
        logic [NTHR-1:0] lvl;
        logic [NTHR-1:0] en;
    } ctrl_t;
endpackage

// File: rtl/bufthr_match.sv
module bufthr_match #(
    parameter int OFS_W = 8
) (
    input  logic             adv_i,
    input  logic [OFS_W-1:0] ofs_i,
    input  logic [OFS_W-1:0] thr_i,
    output logic             hit_o
);
    // a threshold is seen only on an advance step landing on it
    always_comb begin
        hit_o = adv_i && (ofs_i == thr_i);
    end
endmodule

// File: rtl/bufthr_chan.sv
module bufthr_chan (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hit_i,
    input  logic en_i,
    input  logic lvl_i,
    input  logic clr_i,
    output logic status_o,
    output logic irq_o
);
    typedef struct packed {
        logic st;
        logic pls;
    } chan_t;

    chan_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        // a crossing wins over a simultaneous clear
        s_d.st  = (s_q.st & ~clr_i) | hit_i;
        s_d.pls = hit_i & en_i & ~lvl_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign status_o = s_q.st;
    assign irq_o    = lvl_i ? (s_q.st & en_i) : s_q.pls;
endmodule

// File: rtl/bufthr_regs.sv
module bufthr_regs
    import bufthr_pkg::*;
#(
    parameter int OFS_W = 8
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       wr_i,
    input  logic [1:0]                 addr_i,
    input  logic [OFS_W-1:0]           wdata_i,
    input  logic [NTHR-1:0]            status_i,
    output logic [NTHR-1:0][OFS_W-1:0] thr_o,
    output ctrl_t                      ctrl_o,
    output logic [NTHR-1:0]            clr_o,
    output logic [OFS_W-1:0]           rdata_o
);
    localparam int CTRL_W = 2 * NTHR;

    typedef struct packed {
        logic [NTHR-1:0][OFS_W-1:0] thr;
        ctrl_t                      ctrl;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_i) begin
            for (int i = 0; i < NTHR; i++) begin
                if (addr_i == 2'(i)) r_d.thr[i] = wdata_i;
            end
            if (addr_i == A_CTRL) r_d.ctrl = ctrl_t'(wdata_i[CTRL_W-1:0]);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    always_comb begin
        clr_o = (wr_i && addr_i == A_STAT) ? wdata_i[NTHR-1:0] : '0;
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_THR0:  rdata_o = r_q.thr[0];
            A_THR1:  rdata_o = r_q.thr[1];
            A_CTRL:  rdata_o[CTRL_W-1:0] = r_q.ctrl;
            default: rdata_o[NTHR-1:0] = status_i;
        endcase
    end

    assign thr_o  = r_q.thr;
    assign ctrl_o = r_q.ctrl;
endmodule

// File: rtl/bufthr_irq.sv
module bufthr_irq
    import bufthr_pkg::*;
#(
    parameter int OFS_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             adv_i,
    input  logic [OFS_W-1:0] ofs_i,
    input  logic             wr_i,
    input  logic [1:0]       addr_i,
    input  logic [OFS_W-1:0] wdata_i,
    output logic [OFS_W-1:0] rdata_o,
    output logic [NTHR-1:0]  irq_o
);
    logic [NTHR-1:0][OFS_W-1:0] thr_w;
    ctrl_t                      ctrl_w;
    logic [NTHR-1:0]            en_w, lvl_w, clr_w, hit_w, status_w;

    assign en_w  = ctrl_w.en;
    assign lvl_w = ctrl_w.lvl;

    bufthr_regs #(.OFS_W(OFS_W)) u_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_i     (wr_i),
        .addr_i   (addr_i),
        .wdata_i  (wdata_i),
        .status_i (status_w),
        .thr_o    (thr_w),
        .ctrl_o   (ctrl_w),
        .clr_o    (clr_w),
        .rdata_o  (rdata_o)
    );

    for (genvar g = 0; g < NTHR; g++) begin : g_thr
        bufthr_match #(.OFS_W(OFS_W)) u_match (
            .adv_i (adv_i),
            .ofs_i (ofs_i),
            .thr_i (thr_w[g]),
            .hit_o (hit_w[g])
        );

        bufthr_chan u_chan (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .hit_i    (hit_w[g]),
            .en_i     (en_w[g]),
            .lvl_i    (lvl_w[g]),
            .clr_i    (clr_w[g]),
            .status_o (status_w[g]),
            .irq_o    (irq_o[g])
        );
    end
endmodule

// File: rtl/bufthr_irq_chk.sv
module bufthr_irq_chk #(
    parameter int OFS_W = 8,
    parameter int NT    = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     adv,
    input logic [OFS_W-1:0]         ofs,
    input logic [NT-1:0][OFS_W-1:0] thr,
    input logic [NT-1:0]            en,
    input logic [NT-1:0]            lvl,
    input logic [NT-1:0]            clr,
    input logic [NT-1:0]            status,
    input logic [NT-1:0]            irq
);
    for (genvar i = 0; i < NT; i++) begin : g_chk
        p_hit_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (adv && ofs == thr[i]) |=> status[i]);

        p_irq_needs_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> status[i]);

        p_pulse_due_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (adv && ofs == thr[i] && en[i] && !lvl[i]) |=> (lvl[i] || irq[i]));

        p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !(adv && ofs == thr[i])) |=> !status[i]);

        p_clr_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && adv && ofs == thr[i]) |=> status[i]);

        p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr[i] && !adv) |=> (status[i] == $past(status[i])));

        p_en_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (lvl[i] && !en[i]) |-> !irq[i]);
    end
endmodule

bind bufthr_irq bufthr_irq_chk #(.OFS_W(OFS_W), .NT(bufthr_pkg::NTHR)) u_chk (
    .clk    (clk_i),
    .rst_n  (rst_ni),
    .adv    (adv_i),
    .ofs    (ofs_i),
    .thr    (thr_w),
    .en     (en_w),
    .lvl    (lvl_w),
    .clr    (clr_w),
    .status (status_w),
    .irq    (irq_o)
);

// File: tb/bufthr_irq_tb.sv
`timescale 1ns/1ps
module bufthr_irq_tb;
    localparam int OW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          adv = 1'b0;
    logic [OW-1:0] ofs = '0;
    logic          wr = 1'b0;
    logic [1:0]    addr = '0;
    logic [OW-1:0] wdata = '0;
    logic [OW-1:0] rdata;
    logic [1:0]    irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // bench-side model
    logic [OW-1:0] m_thr [2];
    logic [1:0]    m_en, m_lvl, m_st, m_pls;

    always #10 clk = ~clk;

    bufthr_irq #(.OFS_W(OW)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .adv_i(adv), .ofs_i(ofs),
        .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .irq_o(irq)
    );

    function automatic logic [OW-1:0] exp_read(input logic [1:0] a);
        logic [OW-1:0] v = '0;
        case (a)
            2'd0: v = m_thr[0];
            2'd1: v = m_thr[1];
            2'd2: v[3:0] = {m_lvl, m_en};
            default: v[1:0] = m_st;
        endcase
        return v;
    endfunction

    task automatic chk(input logic [OW-1:0] act, input logic [OW-1:0] exp, input string tag, input string what);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // one step: drive at falling edge, register at rising edge, compare at next falling edge
    task automatic cyc(input logic a, input logic [OW-1:0] o, input logic w,
                       input logic [1:0] ad, input logic [OW-1:0] d, input string tag);
        logic [1:0] hit;
        adv = a; ofs = o; wr = w; addr = ad; wdata = d;
        for (int i = 0; i < 2; i++) begin
            hit[i]   = a && (o == m_thr[i]);
            m_pls[i] = hit[i] && m_en[i] && !m_lvl[i];
            m_st[i]  = (m_st[i] && !(w && ad == 2'd3 && d[i])) || hit[i];
        end
        if (w && ad == 2'd0) m_thr[0] = d;
        if (w && ad == 2'd1) m_thr[1] = d;
        if (w && ad == 2'd2) begin m_en = d[1:0]; m_lvl = d[3:2]; end
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < 2; i++) begin
            chk({7'd0, irq[i]}, {7'd0, m_lvl[i] ? (m_st[i] && m_en[i]) : m_pls[i]}, tag, $sformatf("irq%0d", i));
        end
        chk(rdata, exp_read(ad), tag, $sformatf("rdata@%0d", ad));
    endtask

    task automatic walk(input int from, input int to, input string tag);
        for (int k = from; k <= to; k++) cyc(1'b1, OW'(k), 1'b0, 2'd3, '0, tag);
    endtask

    initial begin
        #4ms;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        m_thr[0] = '0; m_thr[1] = '0; m_en = '0; m_lvl = '0; m_st = '0; m_pls = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values of every register and outputs
        for (int a = 0; a < 4; a++) cyc(1'b0, '0, 1'b0, 2'(a), '0, "R1");

        // R2: program mid-buffer and last-eight-bytes thresholds, read back
        cyc(1'b0, '0, 1'b1, 2'd0, 8'd128, "R2");
        cyc(1'b0, '0, 1'b1, 2'd1, 8'd248, "R2");
        cyc(1'b0, '0, 1'b1, 2'd2, 8'hFF, "R2");   // upper bits dropped
        for (int a = 0; a < 4; a++) cyc(1'b0, '0, 1'b0, 2'(a), '0, "R2");

        // R3: level style, both enabled, full ring walk
        walk(0, 255, "R3");

        // R6: writing 0 keeps status, writing 1 clears
        cyc(1'b0, '0, 1'b1, 2'd3, 8'h00, "R6");
        cyc(1'b0, '0, 1'b1, 2'd3, 8'h01, "R6");
        cyc(1'b0, '0, 1'b1, 2'd3, 8'h02, "R6");

        // R4: enables off, crossings set status, outputs stay low
        cyc(1'b0, '0, 1'b1, 2'd2, 8'h0C, "R4");
        walk(120, 250, "R4");
        cyc(1'b0, '0, 1'b1, 2'd3, 8'h03, "R4");

        // R5: pulse style, both enabled
        cyc(1'b0, '0, 1'b1, 2'd2, 8'h03, "R5");
        walk(100, 255, "R5");

        // R8: hold on threshold A without advancing, then wrap around
        cyc(1'b0, '0, 1'b1, 2'd3, 8'h03, "R8");
        cyc(1'b1, 8'd128, 1'b0, 2'd3, '0, "R8");
        for (int k = 0; k < 4; k++) cyc(1'b0, 8'd128, 1'b0, 2'd3, '0, "R8");
        cyc(1'b1, 8'd129, 1'b0, 2'd3, '0, "R8");
        walk(0, 130, "R8");

        // R7: clear coinciding with a crossing leaves status set
        cyc(1'b1, 8'd128, 1'b1, 2'd3, 8'h03, "R7");
        cyc(1'b0, 8'd128, 1'b0, 2'd3, '0, "R7");

        // R9: level style, drop enable, status stays
        cyc(1'b0, '0, 1'b1, 2'd2, 8'h0F, "R9");
        walk(240, 250, "R9");
        cyc(1'b0, '0, 1'b1, 2'd2, 8'h0C, "R9");
        cyc(1'b0, '0, 1'b0, 2'd3, '0, "R9");
        cyc(1'b0, '0, 1'b1, 2'd2, 8'h0F, "R9");

        // R3: sweep threshold pairs and style mixes over full rings
        for (int k = 0; k < 16; k++) begin
            cyc(1'b0, '0, 1'b1, 2'd3, 8'h03, "R3");
            cyc(1'b0, '0, 1'b1, 2'd0, OW'(k * 17), "R3");
            cyc(1'b0, '0, 1'b1, 2'd1, OW'(255 - k * 16), "R3");
            cyc(1'b0, '0, 1'b1, 2'd2, {4'd0, 2'(k), 2'b11}, "R3");
            walk(0, 255, "R3");
        end

        adv = 1'b0; wr = 1'b0;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule